// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block is a half-duplex parallel port that moves 8- or 16-bit words between a small local register interface and an external peer. One control word sets the transfer direction and the protocol of the main byte lane (bits 7:0 of the data bus) and its control pins. The protocol is one of four: lanes off, transparent pass-through, interlocked handshake or pulsed handshake. The control word also sets the mode of the extension byte lane (bits 15:8), whether the hold pin takes part, and one of four receive acknowledge timings for pulsed receive.

A transmit transfer starts when software writes the data register in a handshake mode. The block then drives the word and raises a strobe, and it finishes on the peer's acknowledge. A receive transfer starts on a rising peer strobe. The block captures the word and answers on its own acknowledge pin. Three sticky event bits record a transmitted word, a received word and a receive overrun. Writing a one to an event bit clears it. A mask selects which events reach the single interrupt output. All pin inputs are taken as already synchronous to `clk`.

Top module: `pport_hs`

## Requirements
- R1: After reset the control, event and mask registers read 0, and `pd_oe`, `strobe_o`, `ack_o`, `hold_oe`, `hold_o` and `irq` are all 0.
- R2: The control register (address 0) has these fields: bit 0 direction (1 = transmit), bits 2:1 main mode (00 off, 01 transparent, 10 interlocked, 11 pulsed), bits 4:3 extension mode, bit 5 hold enable, bits 7:6 receive timing. It reads back what was written. A write is dropped while a transmit or receive transfer is in progress.
- R3: With main mode 00, a data-register write raises no strobe, a peer strobe is not answered and records no event, and no main-lane output enable is set.
- R4: In transparent mode with transmit, the lane pins follow the data register, and writing address 3 updates them in the next cycle. With receive, a read of address 3 returns the live pin values. A peer strobe records no event.
- R5: Extension mode 00 turns the upper lane off: its output enable is 0 and it reads as 0. Extension mode 01 makes the upper lane transparent. Extension mode 1x makes the upper lane follow the main mode. Each lane's output enable is set only when transmitting and that lane's mode is not off.
- R6: Interlocked transmit drives the word, holds it for at least one cycle, then raises `strobe_o`. The strobe stays high until `ack_i` is seen high, and event bit 0 is set only after `ack_i` has gone low again.
- R7: Pulsed transmit holds `strobe_o` low for at least one setup cycle after the write, then keeps it high for exactly PULSE_CLKS cycles. Event bit 0 is set once an `ack_i` pulse has been seen, including a pulse that arrives while the strobe is still high.
- R8: When transmitting with hold enable set, `strobe_o` does not rise while `hold_i` is high. With hold enable clear, `hold_i` has no effect.
- R9: When receiving with hold enable set and main mode not off, `hold_oe` is 1. In that case `hold_o` is high while a received word is unread or a receive handshake is in progress, whatever the extension mode. With hold enable clear, `hold_oe` and `hold_o` stay 0.
- R10: Interlocked receive captures `pd_i` on a rising `strobe_i`. It keeps `ack_o` high until `strobe_i` falls and sets event bit 1. A read of address 3 returns the captured word and marks it read.
- R11: Pulsed receive with timing value t raises `ack_o` for exactly one cycle, t cycles after the cycle in which the word is captured, and sets event bit 1.
- R12: A word captured while the previous one is still unread sets event bit 2 (overrun), and the new word replaces the old one.
- R13: The event register is at address 1. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R14: `irq` is high exactly when some event bit is set and its mask bit (address 2) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only at address 3) |
| addr | input | 2 | Register address: 0 control, 1 events, 2 mask, 3 data |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt, OR of masked events |
| pd_i | input | DW | Data pins in |
| pd_o | output | DW | Data pins out |
| pd_oe | output | DW | Per-bit output enable of the data pins |
| strobe_o | output | 1 | Transmit strobe to peer |
| ack_i | input | 1 | Acknowledge from peer during transmit |
| strobe_i | input | 1 | Strobe from peer during receive |
| ack_o | output | 1 | Acknowledge to peer during receive |
| hold_i | input | 1 | Peer hold, gates the transmit strobe |
| hold_o | output | 1 | Hold request to peer during receive |
| hold_oe | output | 1 | Output enable of the hold pin |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, PULSE_CLKS = 4 and SETUP_CLKS = 1. These values let it count the exact strobe width and probe the shortest setup. The full two-lane bus lets it try every pairing of main and extension lane modes, both random and directed. It walks all four receive timing values and checks the single acknowledge cycle at its exact offset. It also covers overrun, hold gating in both directions, and control writes made in the middle of a transfer.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    PM_OFF   = 2'b00,
    PM_THRU  = 2'b01,
    PM_LOCK  = 2'b10,
    PM_PULSE = 2'b11
  } pmode_e;

  typedef struct packed {
    logic [1:0] rx_timing;
    logic       hold_en;
    logic [1:0] ext_mode;
    logic [1:0] main_mode;
    logic       dir;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam int EV_TX  = 0;
  localparam int EV_RX  = 1;
  localparam int EV_OVR = 2;
  localparam int NEV    = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_EVT  = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  // Effective mode of the extension lane: 1x follows the main lane
  function automatic pmode_e ext_lane_mode(input logic [1:0] ext, input logic [1:0] main);
    return ext[1] ? pmode_e'(main) : pmode_e'(ext);
  endfunction

  function automatic logic is_handshake(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic              ctrl_wr_ok,
  input  logic [NEV-1:0]    ev_set,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NEV-1:0]    ev_q,
  output logic [NEV-1:0]    mask_q,
  output logic              irq
);

  logic [NEV-1:0] ev_clr;

  assign ev_clr = (wr_en && addr == A_EVT) ? wdata[NEV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en && addr == A_CTRL && ctrl_wr_ok) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en && addr == A_MASK) mask_q <= wdata[NEV-1:0];
      ev_q <= (ev_q & ~ev_clr) | ev_set;
    end
  end

  assign irq = |(ev_q & mask_q);

endmodule

// File: rtl/pport_tx.sv
module pport_tx #(
  parameter int PULSE_CLKS = 4,
  parameter int SETUP_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pulsed,
  input  logic hold_en,
  input  logic hold_i,
  input  logic ack_i,
  output logic strobe_o,
  output logic idle,
  output logic done
);

  localparam int CNT_MAX = (PULSE_CLKS > SETUP_CLKS) ? PULSE_CLKS : SETUP_CLKS;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CLKS - 1);

  typedef enum logic [2:0] {T_IDLE, T_SETUP, T_STRB, T_ACKLO, T_ACKWAIT} tstate_e;

  tstate_e       st;
  logic [CW-1:0] cnt;
  logic          ack_seen;
  logic          held;

  assign held = hold_en && hold_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      cnt      <= '0;
      ack_seen <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (start) begin
          st       <= T_SETUP;
          cnt      <= '0;
          ack_seen <= 1'b0;
        end
        T_SETUP: begin
          if (cnt == SETUP_LAST) begin
            if (!held) begin
              st  <= T_STRB;
              cnt <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_STRB: begin
          if (pulsed) begin
            if (ack_i) ack_seen <= 1'b1;
            if (cnt == PULSE_LAST) st <= T_ACKWAIT;
            else cnt <= cnt + 1'b1;
          end else if (ack_i) begin
            st <= T_ACKLO;
          end
        end
        T_ACKLO:   if (!ack_i) st <= T_IDLE;
        T_ACKWAIT: if (ack_i || ack_seen) st <= T_IDLE;
        default:   st <= T_IDLE;
      endcase
    end
  end

  assign strobe_o = (st == T_STRB);
  assign idle     = (st == T_IDLE);
  assign done     = (st == T_ACKLO && !ack_i) || (st == T_ACKWAIT && (ack_i || ack_seen));

endmodule

// File: rtl/pport_rx.sv
module pport_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          pulsed,
  input  logic [1:0]    timing,
  input  logic          strobe_i,
  input  logic [DW-1:0] pd_i,
  input  logic          rd_take,
  output logic          ack_o,
  output logic          idle,
  output logic          cap,
  output logic          full_q,
  output logic          ovr,
  output logic          hold_req,
  output logic [DW-1:0] word_q
);

  typedef enum logic [1:0] {R_IDLE, R_ACK, R_DLY, R_PULSE} rstate_e;

  rstate_e    st;
  logic [1:0] cnt;
  logic       strobe_q;

  assign cap = active && strobe_i && !strobe_q && (st == R_IDLE);
  assign ovr = cap && full_q && !rd_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= R_IDLE;
      cnt      <= '0;
      strobe_q <= 1'b0;
      full_q   <= 1'b0;
      word_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (cap) begin
        word_q <= pd_i;
        full_q <= 1'b1;
      end else if (rd_take) begin
        full_q <= 1'b0;
      end
      case (st)
        R_IDLE: if (cap) begin
          cnt <= '0;
          if (!pulsed)            st <= R_ACK;
          else if (timing == 2'd0) st <= R_PULSE;
          else                    st <= R_DLY;
        end
        R_ACK: if (!strobe_i) st <= R_IDLE;
        R_DLY: begin
          if (cnt == timing - 2'd1) st <= R_PULSE;
          else cnt <= cnt + 2'd1;
        end
        R_PULSE: st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  assign ack_o    = (st == R_ACK) || (st == R_PULSE);
  assign idle     = (st == R_IDLE);
  assign hold_req = full_q || (st != R_IDLE);

endmodule

// File: rtl/pport_hs.sv
module pport_hs
  import pport_pkg::*;
#(
  parameter int DW         = 16,
  parameter int PULSE_CLKS = 4,
  parameter int SETUP_CLKS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic [DW-1:0] pd_oe,
  output logic          strobe_o,
  input  logic          ack_i,
  input  logic          strobe_i,
  output logic          ack_o,
  input  logic          hold_i,
  output logic          hold_o,
  output logic          hold_oe
);

  localparam int NLANE  = 2;
  localparam int LANE_W = DW / NLANE;

  logic [CTRL_W-1:0] ctrl_q;
  logic [NEV-1:0]    ev_q, mask_q, ev_set;
  ctrl_t             cfg;
  logic              cfg_dir, cfg_hold_en, hs;
  logic [1:0]        cfg_main;
  logic              tx_idle, rx_idle, tx_done, tx_start;
  logic              rx_cap, rx_full, rx_ovr, rx_hold_req, rx_take;
  logic              ctrl_wr_ok, data_wr;
  logic [DW-1:0]     txd_q, rx_word, data_rd;

  assign cfg         = ctrl_t'(ctrl_q);
  assign cfg_dir     = cfg.dir;
  assign cfg_main    = cfg.main_mode;
  assign cfg_hold_en = cfg.hold_en;
  assign hs          = is_handshake(cfg_main);

  assign data_wr    = wr_en && addr == A_DATA;
  assign tx_start   = data_wr && cfg_dir && hs && tx_idle;
  assign rx_take    = rd_en && addr == A_DATA;
  assign ctrl_wr_ok = tx_idle && rx_idle && !rx_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) txd_q <= '0;
    else if (data_wr && (!hs || tx_idle)) txd_q <= wdata;
  end

  pport_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_wr_ok(ctrl_wr_ok), .ev_set(ev_set), .ctrl_q(ctrl_q),
    .ev_q(ev_q), .mask_q(mask_q), .irq(irq)
  );

  pport_tx #(.PULSE_CLKS(PULSE_CLKS), .SETUP_CLKS(SETUP_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .pulsed(cfg_main == PM_PULSE),
    .hold_en(cfg_hold_en), .hold_i(hold_i), .ack_i(ack_i),
    .strobe_o(strobe_o), .idle(tx_idle), .done(tx_done)
  );

  pport_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(!cfg_dir && hs), .pulsed(cfg_main == PM_PULSE),
    .timing(cfg.rx_timing), .strobe_i(strobe_i), .pd_i(pd_i), .rd_take(rx_take),
    .ack_o(ack_o), .idle(rx_idle), .cap(rx_cap), .full_q(rx_full), .ovr(rx_ovr),
    .hold_req(rx_hold_req), .word_q(rx_word)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_TX]  = tx_done;
    ev_set[EV_RX]  = rx_cap;
    ev_set[EV_OVR] = rx_ovr;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    pmode_e lm;
    if (g == 0) begin : g_main
      assign lm = pmode_e'(cfg_main);
    end else begin : g_ext
      assign lm = ext_lane_mode(cfg.ext_mode, cfg_main);
    end
    assign pd_oe[g*LANE_W +: LANE_W] = {LANE_W{cfg_dir && lm != PM_OFF}};
    assign pd_o[g*LANE_W +: LANE_W]  = txd_q[g*LANE_W +: LANE_W];
    assign data_rd[g*LANE_W +: LANE_W] =
      (lm == PM_OFF)  ? '0 :
      (lm == PM_THRU) ? pd_i[g*LANE_W +: LANE_W] : rx_word[g*LANE_W +: LANE_W];
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DW'(ctrl_q);
      A_EVT:   rdata = DW'(ev_q);
      A_MASK:  rdata = DW'(mask_q);
      default: rdata = data_rd;
    endcase
  end

  assign hold_oe = cfg_hold_en && !cfg_dir && (cfg_main != PM_OFF);
  assign hold_o  = hold_oe && rx_hold_req;

endmodule

// File: rtl/pport_hs_chk.sv
module pport_hs_chk
  import pport_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DW-1:0]     wdata,
  input logic              irq,
  input logic              strobe_o,
  input logic              strobe_i,
  input logic              ack_o,
  input logic              hold_i,
  input logic              cfg_dir,
  input logic [1:0]        cfg_main,
  input logic              cfg_hold_en,
  input logic              tx_idle,
  input logic              rx_idle,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [NEV-1:0]    ev_set,
  input logic [NEV-1:0]    ev_q,
  input logic [NEV-1:0]    mask_q
);

  p_ctrl_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_idle && rx_idle) |=> $stable(ctrl_q));

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_main == 2'b00 |-> !strobe_o && !ack_o);

  p_strobe_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> cfg_dir);

  p_hold_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) && cfg_hold_en |-> !$past(hold_i));

  p_ack_until_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_main == 2'b10 && !cfg_dir && ack_o && strobe_i |=> ack_o);

  p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_main == 2'b11 && !cfg_dir && ack_o |=> !ack_o);

  p_w1c_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd1 && ev_set == '0 |=> (ev_q & $past(wdata[NEV-1:0])) == '0);

  p_irq_follow_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set & mask_q) != '0 && !(wr_en && (addr == 2'd1 || addr == 2'd2)) |=> irq);

endmodule

bind pport_hs pport_hs_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pport_hs.sv
module tb_pport_hs;

  localparam int DW = 16;
  localparam int PULSE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0, rdata, pd_i = '0, pd_o, pd_oe;
  logic          irq, strobe_o, ack_o, hold_o, hold_oe;
  logic          ack_i = 1'b0, strobe_i = 1'b0, hold_i = 1'b0;

  int n_chk = 0, n_err = 0;
  bit done_flag = 1'b0;

  pport_hs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .pd_i(pd_i), .pd_o(pd_o),
    .pd_oe(pd_oe), .strobe_o(strobe_o), .ack_i(ack_i), .strobe_i(strobe_i),
    .ack_o(ack_o), .hold_i(hold_i), .hold_o(hold_o), .hold_oe(hold_oe)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // control word in the bench's own terms
  function automatic logic [15:0] cw(input logic d, input logic [1:0] m, input logic [1:0] e,
                                     input logic h, input logic [1:0] t);
    return {8'h00, t, h, e, m, d};
  endfunction

  function automatic logic [1:0] ext_eff(input logic [15:0] c);
    return c[4] ? c[2:1] : c[4:3];
  endfunction

  function automatic logic [15:0] oe_expect(input logic [15:0] c);
    logic [15:0] r;
    r[7:0]  = (c[0] && c[2:1] != 2'b00) ? 8'hFF : 8'h00;
    r[15:8] = (c[0] && ext_eff(c) != 2'b00) ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_strobe(input logic v, input int lim, output bit found);
    found = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (strobe_o == v) begin found = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_lock_ack();
    bit f;
    ack_i = 1'b1;
    wait_strobe(1'b0, 10, f);
    ack_i = 1'b0;
    tick(1);
  endtask

  task automatic rx_lock(input logic [15:0] w);
    @(negedge clk); pd_i = w; strobe_i = 1'b1;
    @(negedge clk); strobe_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d, w, w2, c;
    bit f;
    int hi, first, ones;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, d); chk("R1 ctrl", d, 0);
    peek(2'd1, d); chk("R1 events", d, 0);
    peek(2'd2, d); chk("R1 mask", d, 0);
    chk("R1 outputs", {pd_oe, strobe_o, ack_o, hold_oe, hold_o, irq}, 0);

    // R3 lanes off: no transfer starts, peer strobe ignored
    wr(2'd3, 16'hA5C3); tick(4);
    chk("R3 no strobe", strobe_o, 0);
    chk("R3 oe", pd_oe, 0);
    @(negedge clk); strobe_i = 1'b1; @(negedge clk);
    chk("R3 no ack", ack_o, 0);
    strobe_i = 1'b0; tick(1);
    peek(2'd1, d); chk("R3 no event", d, 0);

    // R2 / R5 random non-handshake configs: readback and lane enables
    for (int i = 0; i < 16; i++) begin
      c = cw(1'($urandom), {1'b0, 1'($urandom)}, 2'($urandom), 1'b0, 2'($urandom));
      wr(2'd0, c);
      peek(2'd0, d); chk("R2 readback", d, c);
      chk("R5 lane oe", pd_oe, oe_expect(c));
    end
    wr(2'd0, cw(1, 1, 0, 0, 0)); chk("R5 ext off oe", pd_oe, 16'h00FF);
    wr(2'd0, cw(1, 0, 1, 0, 0)); chk("R5 ext thru oe", pd_oe, 16'hFF00);
    wr(2'd0, cw(1, 0, 3, 0, 0)); chk("R5 ext follow oe", pd_oe, 16'h0000);

    // R4 transparent transmit and receive
    wr(2'd0, cw(1, 1, 1, 0, 0));
    for (int i = 0; i < 6; i++) begin
      w = 16'($urandom);
      wr(2'd3, w);
      chk("R4 tx pins", pd_o, w);
      chk("R4 tx oe", pd_oe, 16'hFFFF);
    end
    wr(2'd0, cw(0, 1, 1, 0, 0));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); pd_i = 16'($urandom);
      peek(2'd3, d); chk("R4 rx live", d, pd_i);
    end
    wr(2'd0, cw(0, 1, 0, 0, 0));
    @(negedge clk); pd_i = 16'h9E71;
    peek(2'd3, d); chk("R5 ext off reads 0", d, 16'h0071);
    rx_lock(16'h1234);
    peek(2'd1, d); chk("R4 no event", d, 0);

    // R6 interlocked transmit, R2 lock, R13 clear
    wr(2'd0, cw(1, 2, 2, 0, 0));
    w = 16'($urandom);
    wr(2'd3, w);
    chk("R6 setup low", strobe_o, 0);
    wait_strobe(1'b1, 10, f); chk("R6 strobe rose", f, 1);
    chk("R6 data", pd_o, w);
    wr(2'd0, cw(0, 0, 0, 0, 0));
    peek(2'd0, d); chk("R2 locked", d, cw(1, 2, 2, 0, 0));
    chk("R6 strobe waits ack", strobe_o, 1);
    ack_i = 1'b1;
    wait_strobe(1'b0, 10, f); chk("R6 strobe fell", f, 1);
    tick(2);
    peek(2'd1, d); chk("R6 no event before ack low", d[0], 0);
    ack_i = 1'b0; tick(1);
    peek(2'd1, d); chk("R6 tx event", d[0], 1);
    chk("R14 masked off", irq, 0);
    wr(2'd1, 16'h0000); peek(2'd1, d); chk("R13 write 0 keeps", d[0], 1);
    wr(2'd1, 16'h0001); peek(2'd1, d); chk("R13 write 1 clears", d[0], 0);

    // R6 random interlocked transfers with random acknowledge delay
    for (int i = 0; i < 8; i++) begin
      w = 16'($urandom);
      wr(2'd3, w);
      wait_strobe(1'b1, 10, f);
      chk("R6 rand data", pd_o, w);
      tick(int'($urandom_range(0, 5)));
      finish_lock_ack();
      peek(2'd1, d); chk("R6 rand event", d[0], 1);
      wr(2'd1, 16'h0007);
    end

    // R7 pulsed transmit
    wr(2'd0, cw(1, 3, 3, 0, 0));
    w = 16'($urandom);
    wr(2'd3, w);
    chk("R7 setup low", strobe_o, 0);
    wait_strobe(1'b1, 10, f); chk("R7 strobe rose", f, 1);
    hi = 0;
    while (strobe_o && hi < 20) begin
      if (hi == 1) ack_i = 1'b1; else ack_i = 1'b0;
      hi++;
      @(negedge clk);
    end
    ack_i = 1'b0;
    chk("R7 pulse width", hi, PULSE);
    tick(2);
    peek(2'd1, d); chk("R7 event after early ack", d[0], 1);
    wr(2'd1, 16'h0007);

    // R8 hold gating in transmit
    wr(2'd0, cw(1, 2, 2, 1, 0));
    chk("R9 no hold oe in tx", hold_oe, 0);
    hold_i = 1'b1;
    wr(2'd3, 16'h0F0F); tick(8);
    chk("R8 strobe held off", strobe_o, 0);
    hold_i = 1'b0;
    wait_strobe(1'b1, 4, f); chk("R8 strobe after release", f, 1);
    finish_lock_ack();
    wr(2'd0, cw(1, 2, 2, 0, 0));
    hold_i = 1'b1;
    wr(2'd3, 16'hF0F0);
    wait_strobe(1'b1, 4, f); chk("R8 hold ignored", f, 1);
    finish_lock_ack();
    hold_i = 1'b0;
    wr(2'd1, 16'h0007);

    // R10 / R9 interlocked receive
    wr(2'd0, cw(0, 2, 2, 1, 0));
    chk("R9 hold oe", hold_oe, 1);
    chk("R9 hold idle", hold_o, 0);
    w = 16'($urandom);
    @(negedge clk); pd_i = w; strobe_i = 1'b1;
    @(negedge clk);
    chk("R10 ack up", ack_o, 1);
    chk("R9 hold busy", hold_o, 1);
    tick(2);
    chk("R10 ack stays", ack_o, 1);
    strobe_i = 1'b0;
    @(negedge clk);
    chk("R10 ack down", ack_o, 0);
    chk("R9 hold unread", hold_o, 1);
    peek(2'd1, d); chk("R10 rx event", d[1], 1);
    rd(2'd3, d); chk("R10 data", d, w);
    chk("R9 hold after read", hold_o, 0);

    // R12 overrun
    w = 16'($urandom); w2 = 16'($urandom);
    rx_lock(w); rx_lock(w2);
    peek(2'd1, d); chk("R12 overrun", d[2], 1);
    rd(2'd3, d); chk("R12 newest word", d, w2);
    wr(2'd1, 16'h0007);

    // R9 extension mode does not change hold, R5 lane off on receive
    wr(2'd0, cw(0, 2, 0, 1, 0));
    chk("R9 hold oe ext off", hold_oe, 1);
    rx_lock(16'hBEEF);
    chk("R9 hold ext off", hold_o, 1);
    rd(2'd3, d); chk("R5 ext lane reads 0", d, 16'h00EF);
    wr(2'd0, cw(0, 2, 2, 0, 0));
    rx_lock(16'h4321);
    chk("R9 hold disabled", {hold_oe, hold_o}, 0);
    rd(2'd3, d);
    wr(2'd1, 16'h0007);

    // R11 pulsed receive timing values
    for (int t = 0; t < 4; t++) begin
      wr(2'd0, cw(0, 3, 3, 0, 2'(t)));
      w = 16'($urandom);
      @(negedge clk); pd_i = w; strobe_i = 1'b1;
      @(negedge clk); strobe_i = 1'b0;
      first = -1; ones = 0;
      for (int k = 0; k < 7; k++) begin
        if (ack_o) begin
          ones++;
          if (first < 0) first = k;
        end
        @(negedge clk);
      end
      chk("R11 ack offset", first, t);
      chk("R11 ack width", ones, 1);
      rd(2'd3, d); chk("R11 data", d, w);
    end
    wr(2'd1, 16'h0007);

    // R14 interrupt masking
    wr(2'd2, 16'h0002);
    wr(2'd0, cw(0, 2, 2, 0, 0));
    rx_lock(16'h5555);
    chk("R14 irq rx", irq, 1);
    rd(2'd3, d);
    wr(2'd1, 16'h0002);
    chk("R14 irq cleared", irq, 0);
    wr(2'd0, cw(1, 2, 2, 0, 0));
    wr(2'd3, 16'h3C3C);
    wait_strobe(1'b1, 10, f);
    finish_lock_ack();
    chk("R14 tx masked", irq, 0);
    wr(2'd2, 16'h0001);
    chk("R14 tx unmasked", irq, 1);

    finish_run();
  end

endmodule